// File: doc/BRIEF.md
# Unsigned Small-Float to Single-Precision Expander

This block widens packed, sign-less small floating-point values into IEEE-754 single-precision words. Two source layouts are accepted, picked per sample by a mode input: an 11-bit layout with a 5-bit exponent over a 6-bit fraction, and a 10-bit layout with the same 5-bit exponent over a 5-bit fraction. Every class of source value is covered: zero, denormal, normal, infinity and NaN.

Denormal sources become normal single-precision values. A leading-zero count over the fraction sets both the exponent and the left shift. The result and a valid flag leave the block through one register stage. A sample is taken only in cycles where the input valid is high, and the output word keeps its last value in every other cycle.

Top module: `smallfloat_expand`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), out_valid is 0 and out_word is 0.
- R2: A sample presented with in_valid high on a rising clock edge appears on out_word, with out_valid high, right after that edge. Back-to-back samples each appear one cycle after their own edge.
- R3: In a cycle where in_valid is low at the edge, out_valid goes low after that edge and out_word keeps its previous value, whatever in_bits and fmt_sel carry.
- R4: fmt_sel = 0 selects the 11-bit layout: exponent in in_bits[10:6], fraction in in_bits[5:0]. fmt_sel = 1 selects the 10-bit layout: exponent in in_bits[9:5], fraction in in_bits[4:0]. In the 10-bit layout, in_bits[10] has no effect on the result.
- R5: A source exponent e from 1 to 30 gives an output with exponent field e+112 and the source fraction left-justified in the 23-bit mantissa, so 0x3C0 (11-bit) and 0x1E0 (10-bit) both give 0x3F800000. The largest finite values give 0x477E0000 (65024) and 0x477C0000 (64512).
- R6: A source exponent of 0 with a nonzero fraction gives the normal single-precision value 2^-14 times 0.f. Its exponent field is 112 minus the leading-zero count of the fraction, left-justified to 6 bits, and its mantissa is the bits below the leading one. For example, 11-bit 0x001 gives 0x35800000 and 10-bit 0x001 gives 0x36000000.
- R7: A source exponent of 0 with a zero fraction gives 0x00000000.
- R8: A source exponent of 31 with a zero fraction gives positive infinity, 0x7F800000.
- R9: A source exponent of 31 with a nonzero fraction gives the quiet NaN 0x7FC00000.
- R10: Bit 31 of out_word is 0 whenever out_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present on in_bits this cycle |
| fmt_sel | input | 1 | Source layout: 0 = 11-bit, 1 = 10-bit |
| in_bits | input | 11 | Packed source value; bit 10 unused in 10-bit layout |
| out_valid | output | 1 | out_word carries a new result |
| out_word | output | 32 | Single-precision result |

## Verification
Every converted word is due exactly one rising edge after the edge that samples in_valid high, and the valid flag follows the same single-cycle delay. The bench drives its inputs on the falling edge and reads the result on the next falling edge, half a period after the register has loaded. The bench checks hold behaviour after several idle edges to show that the word stays put over that stretch, and it checks reset immediately after rst_n falls, without waiting for a clock.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    // Source layout widths
    localparam int EXP_W       = 5;
    localparam int FRAC_WIDE   = 6;
    localparam int FRAC_NARROW = 5;
    localparam int IN_W        = EXP_W + FRAC_WIDE;

    // Destination layout widths
    localparam int F32_EXP_W = 8;
    localparam int F32_MAN_W = 23;
    localparam int F32_W     = 1 + F32_EXP_W + F32_MAN_W;
    localparam int F32_BIAS  = (1 << (F32_EXP_W - 1)) - 1;

    // Derived constants
    localparam int SRC_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int BIAS_ADJ = F32_BIAS - SRC_BIAS;
    localparam int LZ_W     = $clog2(FRAC_WIDE + 1);
    localparam int PAD_W    = F32_MAN_W - FRAC_WIDE;

    localparam logic [F32_W-1:0] QNAN_WORD = {1'b0, {F32_EXP_W{1'b1}}, 1'b1, {(F32_MAN_W-1){1'b0}}};
    localparam logic [F32_W-1:0] INF_WORD  = {1'b0, {F32_EXP_W{1'b1}}, {F32_MAN_W{1'b0}}};

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } val_class_e;

    typedef struct packed {
        val_class_e            cls;
        logic [EXP_W-1:0]      expo;
        logic [FRAC_WIDE-1:0]  frac;   // fraction left-justified to FRAC_WIDE
    } fields_t;

    typedef struct packed {
        logic             vld;
        logic [F32_W-1:0] word;
    } stage_t;

endpackage

// File: rtl/sfx_unpack.sv
module sfx_unpack
    import sfx_pkg::*;
(
    input  logic            fmt_narrow,
    input  logic [IN_W-1:0] raw,
    output fields_t         fields
);

    logic [EXP_W-1:0]     exp_wide;
    logic [EXP_W-1:0]     exp_narrow;
    logic [FRAC_WIDE-1:0] frac_wide;
    logic [FRAC_WIDE-1:0] frac_narrow_aligned;

    assign exp_wide   = raw[IN_W-1 -: EXP_W];
    assign exp_narrow = raw[FRAC_NARROW + EXP_W - 1 -: EXP_W];
    assign frac_wide  = raw[FRAC_WIDE-1:0];

    // Narrow fraction is left-justified so both layouts share one datapath
    generate
        if (FRAC_WIDE > FRAC_NARROW) begin : g_pad
            assign frac_narrow_aligned = {raw[FRAC_NARROW-1:0], {(FRAC_WIDE-FRAC_NARROW){1'b0}}};
        end else begin : g_nopad
            assign frac_narrow_aligned = raw[FRAC_WIDE-1:0];
        end
    endgenerate

    always_comb begin
        fields.expo = fmt_narrow ? exp_narrow : exp_wide;
        fields.frac = fmt_narrow ? frac_narrow_aligned : frac_wide;
        if (fields.expo == '1) begin
            fields.cls = (fields.frac != '0) ? CLS_NAN : CLS_INF;
        end else if (fields.expo == '0) begin
            fields.cls = (fields.frac != '0) ? CLS_SUB : CLS_ZERO;
        end else begin
            fields.cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/sfx_lzc.sv
module sfx_lzc #(
    parameter int W   = 6,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] zeros
);

    // Scan upward; the highest set bit is the last to assign
    always_comb begin
        zeros = CNT_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = CNT_W'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/sfx_compose.sv
module sfx_compose
    import sfx_pkg::*;
(
    input  fields_t          fields,
    input  logic [LZ_W-1:0]  lead_zeros,
    output logic [F32_W-1:0] word
);

    logic [F32_EXP_W-1:0] exp_norm;
    logic [F32_EXP_W-1:0] exp_sub;
    logic [FRAC_WIDE-1:0] frac_sub;
    logic [LZ_W:0]        shift_amt;

    assign exp_norm  = F32_EXP_W'(fields.expo) + F32_EXP_W'(BIAS_ADJ);
    assign exp_sub   = F32_EXP_W'(BIAS_ADJ) - F32_EXP_W'(lead_zeros);
    assign shift_amt = {1'b0, lead_zeros} + 1'b1;
    // Shift past the leading one; what remains is the hidden-bit mantissa
    assign frac_sub  = fields.frac << shift_amt;

    always_comb begin
        unique case (fields.cls)
            CLS_ZERO: word = '0;
            CLS_SUB:  word = {1'b0, exp_sub, frac_sub, {PAD_W{1'b0}}};
            CLS_NORM: word = {1'b0, exp_norm, fields.frac, {PAD_W{1'b0}}};
            CLS_INF:  word = INF_WORD;
            CLS_NAN:  word = QNAN_WORD;
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/smallfloat_expand.sv
module smallfloat_expand
    import sfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             fmt_sel,
    input  logic [IN_W-1:0]  in_bits,
    output logic             out_valid,
    output logic [F32_W-1:0] out_word
);

    fields_t          fields;
    logic [LZ_W-1:0]  lead_zeros;
    logic [F32_W-1:0] comb_word;
    stage_t           stage_d;
    stage_t           stage_q;

    sfx_unpack u_unpack (
        .fmt_narrow (fmt_sel),
        .raw        (in_bits),
        .fields     (fields)
    );

    sfx_lzc #(
        .W     (FRAC_WIDE),
        .CNT_W (LZ_W)
    ) u_lzc (
        .vec   (fields.frac),
        .zeros (lead_zeros)
    );

    sfx_compose u_compose (
        .fields     (fields),
        .lead_zeros (lead_zeros),
        .word       (comb_word)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.word = comb_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign out_word  = stage_q.word;

endmodule

// File: rtl/sfx_chk.sv
module sfx_chk
    import sfx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             fmt_sel,
    input logic [IN_W-1:0]  in_bits,
    input logic             out_valid,
    input logic [F32_W-1:0] out_word
);

    logic [EXP_W-1:0] src_exp;
    logic             src_frac_nz;

    assign src_exp     = fmt_sel ? in_bits[FRAC_NARROW + EXP_W - 1 -: EXP_W] : in_bits[IN_W-1 -: EXP_W];
    assign src_frac_nz = fmt_sel ? (in_bits[FRAC_NARROW-1:0] != '0) : (in_bits[FRAC_WIDE-1:0] != '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_word == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(out_word)));

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_exp == '0 && !src_frac_nz) |=> out_word == '0);

    // R8
    inf_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_exp == '1 && !src_frac_nz) |=> out_word == 32'h7F80_0000);

    // R9
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_exp == '1 && src_frac_nz) |=> out_word == 32'h7FC0_0000);

    // R10
    no_sign_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !out_word[F32_W-1]);

endmodule

bind smallfloat_expand sfx_chk u_sfx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fmt_sel   (fmt_sel),
    .in_bits   (in_bits),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/smallfloat_expand_bench.sv
`timescale 1ns/1ps
module smallfloat_expand_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        fmt_sel = 1'b0;
    logic [10:0] in_bits = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    smallfloat_expand u_smallfloat_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .fmt_sel   (fmt_sel),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // {req code, fmt_sel, in_bits, expected word}
    localparam int NV = 19;
    localparam logic [47:0] VEC [NV] = '{
        {4'd5, 1'b0, 11'h3C0, 32'h3F80_0000},
        {4'd5, 1'b1, 11'h1E0, 32'h3F80_0000},
        {4'd5, 1'b0, 11'h7BF, 32'h477E_0000},
        {4'd5, 1'b1, 11'h3DF, 32'h477C_0000},
        {4'd5, 1'b0, 11'h041, 32'h3882_0000},
        {4'd5, 1'b1, 11'h021, 32'h3884_0000},
        {4'd5, 1'b0, 11'h3FF, 32'h3FFE_0000},
        {4'd6, 1'b0, 11'h001, 32'h3580_0000},
        {4'd6, 1'b1, 11'h001, 32'h3600_0000},
        {4'd6, 1'b0, 11'h020, 32'h3800_0000},
        {4'd6, 1'b0, 11'h03F, 32'h387C_0000},
        {4'd6, 1'b1, 11'h010, 32'h3800_0000},
        {4'd6, 1'b1, 11'h00F, 32'h37F0_0000},
        {4'd7, 1'b0, 11'h000, 32'h0000_0000},
        {4'd4, 1'b1, 11'h400, 32'h0000_0000},
        {4'd8, 1'b0, 11'h7C0, 32'h7F80_0000},
        {4'd8, 1'b1, 11'h3E0, 32'h7F80_0000},
        {4'd9, 1'b0, 11'h7C1, 32'h7FC0_0000},
        {4'd4, 1'b1, 11'h7FF, 32'h7FC0_0000}
    };

    function automatic string req_name(input logic [3:0] code);
        case (code)
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;

        // R1: reset state
        #1;
        check("R1", {31'b0, out_valid}, 32'd0);
        check("R1", out_word, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table: R4..R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            fmt_sel  = VEC[i][43];
            in_bits  = VEC[i][42:32];
            @(negedge clk);
            in_valid = 1'b0;
            check("R2", {31'b0, out_valid}, 32'd1);
            check(req_name(VEC[i][47:44]), out_word, VEC[i][31:0]);
            check("R10", {31'b0, out_word[31]}, 32'd0);
        end

        // R3: idle cycles with changing inputs keep the word
        @(negedge clk);
        held = out_word;
        check("R3", {31'b0, out_valid}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            fmt_sel = k[0];
            in_bits = 11'h155 ^ 11'(k * 37);
            @(negedge clk);
            check("R3", out_word, held);
        end

        // R2: back-to-back samples
        @(negedge clk);
        in_valid = 1'b1;
        fmt_sel  = 1'b0;
        in_bits  = 11'h3C0;
        @(negedge clk);
        check("R2", out_word, 32'h3F80_0000);
        fmt_sel = 1'b1;
        in_bits = 11'h3E0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", out_word, 32'h7F80_0000);
        check("R2", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R2", {31'b0, out_valid}, 32'd0);

        // R4: bit 10 ignored in narrow layout for a normal value
        @(negedge clk);
        in_valid = 1'b1;
        fmt_sel  = 1'b1;
        in_bits  = 11'h5E0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4", out_word, 32'h3F80_0000);

        // R1: asynchronous reset while holding a result
        @(negedge clk);
        in_valid = 1'b1;
        fmt_sel  = 1'b0;
        in_bits  = 11'h7BF;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        rst_n = 1'b0;
        #0.5;
        check("R1", {31'b0, out_valid}, 32'd0);
        check("R1", out_word, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule